// File: doc/BRIEF.md
# UART interrupt priority and identification

This block gathers the interrupt sources of a 16550-style serial port into one request line and one 4-bit identification code. Five sources are tracked: a receive line fault (overrun, parity, framing or break), received data at or above the trigger point, a receive FIFO character timeout, an emptied transmit holding register, and a change on the modem control inputs.

The receive line fault, transmit-empty and modem-change sources each keep a sticky pending flag. Each flag is cleared as a side effect of the register access that services that source. The received-data source follows a level input. The character timeout is generated inside the block. It counts 16x bit-rate ticks while the receive FIFO is not empty and nothing is pushed or read. It fires after four character times, and the character length comes from an input.

The baud generator, shift registers, FIFO storage and address decode stay outside the block. They reach it as strobes and status levels. The identification code and the request line are combinational views of the registered state, so a read strobe sees the value as it stood before that read clears anything.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset nothing is pending, `irq` is 0 and `iir_code` reads 4'b0001. Bit 0 set means no interrupt.
- R2: A pulse on any bit of `line_err` makes the line fault pending, and it is reported as 4'b0110 above every other source. A `lsr_read` strobe with no new error clears it.
- R3: The received-data source is pending exactly while `rx_avail` is high. It is reported as 4'b0100 and ranks second.
- R4: With `fifo_mode` high and `rx_nonempty` high, the timeout is raised after 4 × 16 × `frame_bits` ticks of `tick16x` with no `rx_push` and no `rbr_read`. The ticks are counted from the edge that restarted the count, and a `frame_bits` of 0 counts as 1. The timeout is not raised one tick earlier, and it is reported as 4'b1100.
- R5: The timeout is cleared by `rbr_read` and by `fifo_mode` being low. `rx_push`, `rbr_read` and an empty FIFO each restart the tick count.
- R6: When received data and timeout are both pending and enabled, the code is 4'b0100.
- R7: A `thr_emptied` pulse makes transmit-empty pending, reported as 4'b0010 in third place. A `thr_write` strobe clears it.
- R8: An `iir_read` strobe clears transmit-empty only if the code shown during that strobe is 4'b0010. Otherwise transmit-empty stays pending.
- R9: Any change on any bit of `modem_lines` makes modem-change pending, reported as 4'b0000 at the lowest rank. A `msr_read` strobe clears it.
- R10: `src_en` bit 0 enables received data and timeout, bit 1 transmit-empty, bit 2 line fault and bit 3 modem change. A disabled source is left out of both `irq` and `iir_code` but stays pending, and it is reported as soon as it is enabled.
- R11: `irq` is high exactly when an enabled source is pending, which is exactly when `iir_code` bit 0 is 0.
- R12: If a set event and its clearing access fall in the same cycle for the line fault, transmit-empty or modem-change source, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | FIFOs enabled; the timeout exists only while high |
| rx_avail | input | 1 | Receive data at trigger level (or holding register full) |
| rx_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_push | input | 1 | A character was written into the receive FIFO |
| rbr_read | input | 1 | Receive buffer read strobe |
| tick16x | input | 1 | Tick at 16 times the bit rate |
| frame_bits | input | 4 | Bits per character frame |
| line_err | input | 4 | Overrun, parity, framing and break event pulses |
| lsr_read | input | 1 | Line status read strobe |
| thr_emptied | input | 1 | Transmit holding register became empty |
| thr_write | input | 1 | Transmit holding register write strobe |
| iir_read | input | 1 | Identification read strobe |
| modem_lines | input | 4 | CTS, DSR, RI and DCD levels |
| msr_read | input | 1 | Modem status read strobe |
| src_en | input | 4 | Per-source interrupt enables |
| irq | output | 1 | Interrupt request |
| iir_code | output | 4 | Identification code of the highest enabled pending source |

## Verification
The interesting collisions are a source's set event landing on the same cycle as the access that clears it. The cases are a new line error during a line status read, an emptied holding register during a write to it, and a modem edge during a modem status read. The bench drives both strobes in one cycle and expects the code of that source one edge later. A second collision is an identification read while transmit-empty is pending but hidden under a line fault. The bench then removes the line fault and expects 4'b0010 to surface. This shows the read cleared nothing it did not report.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        IID_NONE  = 4'b0001,
        IID_RLS   = 4'b0110,
        IID_RDA   = 4'b0100,
        IID_CTO   = 4'b1100,
        IID_THRE  = 4'b0010,
        IID_MSR   = 4'b0000
    } iid_e;

    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
    localparam int EN_W     = 4;

    typedef struct packed {
        logic rls;
        logic rda;
        logic cto;
        logic thre;
        logic msr;
    } pend_t;

endpackage

// File: rtl/irq_char_timer.sv
module irq_char_timer #(
    parameter int CHAR_TIMES = 4,
    parameter int OVERSAMPLE = 16,
    parameter int FRAME_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_mode,
    input  logic               rx_nonempty,
    input  logic               rx_push,
    input  logic               rbr_read,
    input  logic               tick,
    input  logic [FRAME_W-1:0] frame_bits,
    output logic               cto
);
    localparam int MAX_LIMIT = CHAR_TIMES * OVERSAMPLE * ((1 << FRAME_W) - 1);
    localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             cto;
    } tmr_t;

    tmr_t             st_d, st_q;
    logic [CNT_W-1:0] lim_m1;
    logic             restart;
    logic             fire;
    int               bits_eff;

    always_comb begin
        bits_eff = (frame_bits == '0) ? 1 : int'(frame_bits);
        lim_m1   = CNT_W'(CHAR_TIMES * OVERSAMPLE * bits_eff - 1);
        restart  = rx_push | rbr_read | ~rx_nonempty | ~fifo_mode;
        fire     = tick & ~restart & (st_q.cnt >= lim_m1);

        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (tick && (st_q.cnt < lim_m1)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (rbr_read || !fifo_mode) begin
            st_d.cto = 1'b0;
        end else if (fire) begin
            st_d.cto = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cto = st_q.cto;

    p_cto_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |=> !cto);
    p_cto_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rbr_read |=> !cto);
    p_cto_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cto && fifo_mode && !rbr_read) |=> cto);
    p_cto_need_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cto && (rx_push || !rx_nonempty)) |=> !cto);

endmodule

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
    parameter int ERR_W = 4,
    parameter int MDM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] line_err,
    input  logic             lsr_read,
    input  logic             thr_emptied,
    input  logic             thr_write,
    input  logic             iir_read,
    input  logic             iir_is_thre,
    input  logic [MDM_W-1:0] modem_lines,
    input  logic             msr_read,
    output logic             rls,
    output logic             thre,
    output logic             msr
);
    typedef struct packed {
        logic             rls;
        logic             thre;
        logic             msr;
        logic [MDM_W-1:0] mdm;
        logic             armed;
    } flg_t;

    flg_t st_d, st_q;
    logic mdm_change;
    logic thre_clr;

    always_comb begin
        mdm_change = st_q.armed & (modem_lines != st_q.mdm);
        thre_clr   = thr_write | (iir_read & iir_is_thre);

        st_d       = st_q;
        st_d.rls   = (|line_err) | (st_q.rls & ~lsr_read);
        st_d.thre  = thr_emptied | (st_q.thre & ~thre_clr);
        st_d.msr   = mdm_change | (st_q.msr & ~msr_read);
        st_d.mdm   = modem_lines;
        st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rls  = st_q.rls;
    assign thre = st_q.thre;
    assign msr  = st_q.msr;

    p_rls_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_err) |=> rls);
    p_rls_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_read && !(|line_err)) |=> !rls);
    p_thre_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        thr_emptied |=> thre);
    p_thre_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (thre && iir_read && !iir_is_thre && !thr_write) |=> thre);
    p_thre_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_write && !thr_emptied) |=> !thre);
    p_msr_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msr && msr_read && $stable(modem_lines)) |=> !msr);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  pend_t            pend,
    input  logic [EN_W-1:0]  src_en,
    output iid_e             code,
    output logic             irq
);
    pend_t act;

    always_comb begin
        act.rls  = pend.rls  & src_en[EN_LINE];
        act.rda  = pend.rda  & src_en[EN_RX];
        act.cto  = pend.cto  & src_en[EN_RX];
        act.thre = pend.thre & src_en[EN_TX];
        act.msr  = pend.msr  & src_en[EN_MODEM];

        irq = |act;

        if (act.rls) begin
            code = IID_RLS;
        end else if (act.rda) begin
            code = IID_RDA;
        end else if (act.cto) begin
            code = IID_CTO;
        end else if (act.thre) begin
            code = IID_THRE;
        end else if (act.msr) begin
            code = IID_MSR;
        end else begin
            code = IID_NONE;
        end
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int CHAR_TIMES = 4,
    parameter int OVERSAMPLE = 16,
    parameter int FRAME_W    = 4,
    parameter int ERR_W      = 4,
    parameter int MDM_W      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_mode,
    input  logic               rx_avail,
    input  logic               rx_nonempty,
    input  logic               rx_push,
    input  logic               rbr_read,
    input  logic               tick16x,
    input  logic [FRAME_W-1:0] frame_bits,
    input  logic [ERR_W-1:0]   line_err,
    input  logic               lsr_read,
    input  logic               thr_emptied,
    input  logic               thr_write,
    input  logic               iir_read,
    input  logic [MDM_W-1:0]   modem_lines,
    input  logic               msr_read,
    input  logic [EN_W-1:0]    src_en,
    output logic               irq,
    output logic [3:0]         iir_code
);
    logic  rls_w, thre_w, msr_w, cto_w;
    pend_t pend;
    iid_e  code_w;

    irq_char_timer #(
        .CHAR_TIMES (CHAR_TIMES),
        .OVERSAMPLE (OVERSAMPLE),
        .FRAME_W    (FRAME_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_mode   (fifo_mode),
        .rx_nonempty (rx_nonempty),
        .rx_push     (rx_push),
        .rbr_read    (rbr_read),
        .tick        (tick16x),
        .frame_bits  (frame_bits),
        .cto         (cto_w)
    );

    irq_src_flags #(
        .ERR_W (ERR_W),
        .MDM_W (MDM_W)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_err    (line_err),
        .lsr_read    (lsr_read),
        .thr_emptied (thr_emptied),
        .thr_write   (thr_write),
        .iir_read    (iir_read),
        .iir_is_thre (code_w == IID_THRE),
        .modem_lines (modem_lines),
        .msr_read    (msr_read),
        .rls         (rls_w),
        .thre        (thre_w),
        .msr         (msr_w)
    );

    always_comb begin
        pend.rls  = rls_w;
        pend.rda  = rx_avail;
        pend.cto  = cto_w;
        pend.thre = thre_w;
        pend.msr  = msr_w;
    end

    irq_prio_enc u_prio (
        .pend   (pend),
        .src_en (src_en),
        .code   (code_w),
        .irq    (irq)
    );

    assign iir_code = code_w;

    p_irq_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !iir_code[0]);
    p_rda_rank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_avail && src_en[EN_RX]) |-> (iir_code == 4'b0110 || iir_code == 4'b0100));
    p_mask_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == '0) |-> !irq);
    p_line_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rls_w && src_en[EN_LINE]) |-> iir_code == 4'b0110);

endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_mode, rx_avail, rx_nonempty, rx_push, rbr_read, tick16x;
    logic [3:0] frame_bits, line_err, modem_lines, src_en;
    logic       lsr_read, thr_emptied, thr_write, iir_read, msr_read;
    logic       irq;
    logic [3:0] iir_code;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    uart_irq_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_mode   (fifo_mode),
        .rx_avail    (rx_avail),
        .rx_nonempty (rx_nonempty),
        .rx_push     (rx_push),
        .rbr_read    (rbr_read),
        .tick16x     (tick16x),
        .frame_bits  (frame_bits),
        .line_err    (line_err),
        .lsr_read    (lsr_read),
        .thr_emptied (thr_emptied),
        .thr_write   (thr_write),
        .iir_read    (iir_read),
        .modem_lines (modem_lines),
        .msr_read    (msr_read),
        .src_en      (src_en),
        .irq         (irq),
        .iir_code    (iir_code)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        line_err = '0; thr_emptied = 0; thr_write = 0; lsr_read = 0;
        msr_read = 0; rbr_read = 0; iir_read = 0; rx_push = 0;
    endtask

    // p = {rls, rda, cto, thre, msr}
    function automatic logic [3:0] exp_code(input logic [4:0] p, input logic [3:0] m);
        if (p[4] && m[2]) return 4'b0110;
        if (p[3] && m[0]) return 4'b0100;
        if (p[2] && m[0]) return 4'b1100;
        if (p[1] && m[1]) return 4'b0010;
        if (p[0] && m[3]) return 4'b0000;
        return 4'b0001;
    endfunction

    task automatic clear_all();
        fifo_mode = 0; rx_avail = 0; rx_nonempty = 0;
        lsr_read = 1; msr_read = 1; thr_write = 1;
        step();
        fifo_mode = 1;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0;
        fifo_mode = 1; rx_avail = 0; rx_nonempty = 0; rx_push = 0; rbr_read = 0;
        tick16x = 1; frame_bits = 4'd1; line_err = '0; modem_lines = '0;
        lsr_read = 0; thr_emptied = 0; thr_write = 0; iir_read = 0; msr_read = 0;
        src_en = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();

        // R1 reset state
        chk("R1 code", iir_code, 4'b0001);
        chk("R1 irq", {3'b0, irq}, 4'b0000);

        // Sweep: every pending set against every enable mask (R6, R10, R11)
        for (int c = 0; c < 32; c++) begin
            logic [4:0] p;
            p = 5'(c);
            clear_all();
            rx_nonempty = p[2];
            rx_push = p[2];
            step();
            if (p[2]) repeat (70) step();
            if (p[4]) line_err = 4'(1 << (c % 4));
            thr_emptied = p[1];
            if (p[0]) modem_lines[c % 4] = ~modem_lines[c % 4];
            step();
            rx_avail = p[3];
            for (int m = 0; m < 16; m++) begin
                @(negedge clk);
                src_en = 4'(m);
                #1;
                chk("R10 sweep code", iir_code, exp_code(p, 4'(m)));
                chk("R11 sweep irq", {3'b0, irq}, {3'b0, exp_code(p, 4'(m)) != 4'b0001});
            end
        end
        src_en = 4'hF;
        clear_all();
        rx_nonempty = 0;

        // R2 and R12: error during a status read stays pending
        line_err = 4'b0100; lsr_read = 1; step();
        chk("R12 rls set wins", iir_code, 4'b0110);
        lsr_read = 1; step();
        chk("R2 rls cleared", iir_code, 4'b0001);

        // R7
        thr_emptied = 1; step();
        chk("R7 thre set", iir_code, 4'b0010);
        thr_write = 1; step();
        chk("R7 thre cleared", iir_code, 4'b0001);
        // R12 on transmit-empty, then R8 clear by identification read
        thr_emptied = 1; thr_write = 1; step();
        chk("R12 thre set wins", iir_code, 4'b0010);
        iir_read = 1; step();
        chk("R8 thre cleared by id read", iir_code, 4'b0001);
        // R8 hidden transmit-empty survives identification read
        thr_emptied = 1; line_err = 4'b0001; step();
        chk("R2 rls over thre", iir_code, 4'b0110);
        iir_read = 1; step();
        chk("R8 id read with rls shown", iir_code, 4'b0110);
        lsr_read = 1; step();
        chk("R8 thre survived", iir_code, 4'b0010);
        thr_write = 1; step();

        // R9 each modem line
        for (int b = 0; b < 4; b++) begin
            modem_lines[b] = ~modem_lines[b]; step();
            chk("R9 modem change", iir_code, 4'b0000);
            chk("R9 modem irq", {3'b0, irq}, 4'b0001);
            msr_read = 1; step();
            chk("R9 modem cleared", iir_code, 4'b0001);
        end
        modem_lines[2] = ~modem_lines[2]; msr_read = 1; step();
        chk("R12 msr set wins", iir_code, 4'b0000);
        msr_read = 1; step();

        // R3
        thr_emptied = 1; step();
        rx_avail = 1; #1;
        chk("R3 rda over thre", iir_code, 4'b0100);
        rx_avail = 0; #1;
        chk("R3 rda follows level", iir_code, 4'b0010);
        thr_write = 1; step();

        // R4 exact boundary for several frame lengths, R5 clear by read
        rx_nonempty = 1;
        for (int f = 1; f <= 4; f++) begin
            frame_bits = 4'(f);
            rx_push = 1; step();
            repeat (64 * f - 1) step();
            chk("R4 one tick early", iir_code, 4'b0001);
            step();
            chk("R4 timeout raised", iir_code, 4'b1100);
            rbr_read = 1; step();
            chk("R5 read clears timeout", iir_code, 4'b0001);
        end

        // R5 restart by a read mid count, then fifo_mode clears
        frame_bits = 4'd1;
        rx_push = 1; step();
        repeat (40) step();
        rbr_read = 1; step();
        repeat (63) step();
        chk("R5 restart early", iir_code, 4'b0001);
        step();
        chk("R5 restart fires", iir_code, 4'b1100);
        // R6
        rx_avail = 1; #1;
        chk("R6 rda ahead of cto", iir_code, 4'b0100);
        rx_avail = 0; #1;
        chk("R6 cto after rda", iir_code, 4'b1100);
        fifo_mode = 0; step();
        chk("R5 fifo off clears", iir_code, 4'b0001);
        fifo_mode = 1; rx_nonempty = 0; step();

        // R10 masked source kept pending
        src_en = 4'b0000;
        thr_emptied = 1; step();
        chk("R10 masked code", iir_code, 4'b0001);
        chk("R10 masked irq", {3'b0, irq}, 4'b0000);
        src_en = 4'b0010; #1;
        chk("R10 unmasked code", iir_code, 4'b0010);
        chk("R11 unmasked irq", {3'b0, irq}, 4'b0001);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule